// File: doc/BRIEF.md
# Delay Setting Update Controller

This block keeps the control word for a group of strobe delay chains and makes sure every chain picks up a new value on the same clock edge. A Gray-coded step code comes either from the delay-locked-loop path or from core logic. A second selector picks between them. The block also takes a phase-offset value, an element-count choice (one to four active delay elements per chain) and a bypass request that gives zero phase shift.

None of these inputs goes straight to the chains. Each one waits in a holding register. That register loads only while a periodic update-enable pulse is high. The pulse is made by a cadence counter that counts ticks from either a reference timing source or a core timing source, as chosen by a select input.

Before a new code is accepted, it is compared with the code already committed. A code that moves by more than one Gray step is refused and flagged. The committed code is also turned into a binary step count, and from that the block gives a numeric effective delay that stands in for the analog cells.

Top module: `dly_update_ctrl`

## Requirements
- R1: While reset is held and after its release, until the first commit: codeOut=0, stepsOut=0, elemCount=1, phaseOut=0, bypassOut=0, codeErr=0 and updEn=0.
- R2: updEn is high for one cycle after every 8 counted ticks. With ticks present every cycle, the first pulse appears on the 8th rising edge after reset is released.
- R3: tickSel=0 makes the cadence count refTick, and tickSel=1 makes it count userTick. The tick that is not selected has no effect on updEn.
- R4: The committed outputs (codeOut, elemCount, phaseOut, bypassOut, codeErr) change only on the rising edge that ends a cycle in which updEn is high. They take the input values present in that cycle.
- R5: srcSel=0 takes the candidate code from dllCode, and srcSel=1 takes it from coreCode.
- R6: stepsOut is the binary value of the Gray-coded codeOut, where bit i of stepsOut is the XOR of codeOut bits 5 down to i.
- R7: If a candidate differs from the committed code in more than one bit, a commit leaves codeOut unchanged and sets codeErr=1. Otherwise it loads the candidate and sets codeErr=0.
- R8: When narrowMode=1, bit 5 of the candidate code is treated as 0, whatever its input value.
- R9: elemSel values 0, 1, 2 and 3 commit elemCount values 1, 2, 3 and 4.
- R10: When bypass is off, delayOut = elemCount * (20 + stepsOut * 5), using an intrinsic delay of 20 units and a step of 5 units.
- R11: A committed bypassIn=1 gives bypassOut=1 and delayOut=0.
- R12: phaseOut takes phaseIn at each commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickSel | input | 1 | Cadence source: 0 counts refTick, 1 counts userTick |
| refTick | input | 1 | Tick from the reference timing source |
| userTick | input | 1 | Tick from the core timing source |
| srcSel | input | 1 | Code source: 0 uses dllCode, 1 uses coreCode |
| dllCode | input | 6 | Gray code from the delay-locked-loop path |
| coreCode | input | 6 | Gray code from core logic |
| narrowMode | input | 1 | 5-bit code mode, in which bit 5 is ignored |
| elemSel | input | 2 | Active element count minus one |
| phaseIn | input | 6 | Phase-offset setting |
| bypassIn | input | 1 | Zero-delay bypass request |
| updEn | output | 1 | Update-enable pulse |
| codeOut | output | 6 | Committed Gray code |
| stepsOut | output | 6 | Committed step count in binary |
| elemCount | output | 3 | Committed active element count, 1 to 4 |
| phaseOut | output | 6 | Committed phase offset |
| bypassOut | output | 1 | Committed bypass flag |
| delayOut | output | 11 | Effective delay in units |
| codeErr | output | 1 | Set when the last commit refused the code |

## Verification
The stimulus starts with a random walk of one-step Gray neighbours, which shows that codes commit only on the pulse and that the binary conversion holds across the 63-to-0 wrap. Separate phases gate the selected tick at random while the other tick runs freely, and then swap the two. These phases separate the counting of the chosen source from the counting of the wrong one. A narrow-mode phase drives random values on bit 5. An injection phase drives arbitrary codes, which separates correct refusal of multi-bit jumps from wrong acceptance. All through the run, bypass, element selection, phase offset and the unused code source are randomised, so that a wrong source or a wrong delay formula shows up.

// File: rtl/dlyu_pkg.sv
package dlyu_pkg;

  // Strobes from the cadence control to the datapath
  typedef struct packed {
    logic commit;   // load the holding registers at the next edge
    logic refuse;   // unused by default; reserved-free: always zero
  } dlyuStrobe_t;

endpackage

// File: rtl/dlyu_ctrl.sv
module dlyu_ctrl
  import dlyu_pkg::*;
#(
  parameter int PERIOD = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickSel,
  input  logic        refTick,
  input  logic        userTick,
  output logic        updEn,
  output dlyuStrobe_t stb
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] tickCnt;
  logic             tickNow;

  assign tickNow = tickSel ? userTick : refTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      updEn   <= 1'b0;
    end else begin
      updEn <= 1'b0;
      if (tickNow) begin
        if (tickCnt == LAST) begin
          tickCnt <= '0;
          updEn   <= 1'b1;
        end else begin
          tickCnt <= tickCnt + CNT_W'(1);
        end
      end
    end
  end

  assign stb.commit = updEn;
  assign stb.refuse = 1'b0;

endmodule

// File: rtl/dlyu_datapath.sv
module dlyu_datapath
  import dlyu_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int OFF_W     = 6,
  parameter int INTRINSIC = 20,
  parameter int STEP      = 5,
  parameter int DLY_W     = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dlyuStrobe_t       stb,
  input  logic              srcSel,
  input  logic [CODE_W-1:0] dllCode,
  input  logic [CODE_W-1:0] coreCode,
  input  logic              narrowMode,
  input  logic [1:0]        elemSel,
  input  logic [OFF_W-1:0]  phaseIn,
  input  logic              bypassIn,
  output logic [CODE_W-1:0] codeOut,
  output logic [CODE_W-1:0] stepsOut,
  output logic [2:0]        elemCount,
  output logic [OFF_W-1:0]  phaseOut,
  output logic              bypassOut,
  output logic [DLY_W-1:0]  delayOut,
  output logic              codeErr
);
  logic [CODE_W-1:0] candCode;
  logic [CODE_W-1:0] diffBits;
  logic              multiBit;
  logic [CODE_W-1:0] codeQ;
  logic [2:0]        elemQ;
  logic [OFF_W-1:0]  phaseQ;
  logic              bypassQ;
  logic              errQ;

  // candidate selection and narrow-mode masking
  always_comb begin
    candCode = srcSel ? coreCode : dllCode;
    if (narrowMode) candCode[CODE_W-1] = 1'b0;
  end

  assign diffBits = candCode ^ codeQ;
  assign multiBit = (diffBits & (diffBits - CODE_W'(1))) != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ   <= '0;
      elemQ   <= 3'd1;
      phaseQ  <= '0;
      bypassQ <= 1'b0;
      errQ    <= 1'b0;
    end else if (stb.commit && !stb.refuse) begin
      if (!multiBit) codeQ <= candCode;
      errQ    <= multiBit;
      elemQ   <= {1'b0, elemSel} + 3'd1;
      phaseQ  <= phaseIn;
      bypassQ <= bypassIn;
    end
  end

  // Gray to binary: each bit is the parity of the bits at and above it
  for (genvar i = 0; i < CODE_W; i++) begin : g_gray2bin
    assign stepsOut[i] = ^codeQ[CODE_W-1:i];
  end

  always_comb begin
    if (bypassQ) begin
      delayOut = '0;
    end else begin
      delayOut = DLY_W'(elemQ) *
                 (DLY_W'(INTRINSIC) + DLY_W'(stepsOut) * DLY_W'(STEP));
    end
  end

  assign codeOut   = codeQ;
  assign elemCount = elemQ;
  assign phaseOut  = phaseQ;
  assign bypassOut = bypassQ;
  assign codeErr   = errQ;

endmodule

// File: rtl/dly_update_ctrl.sv
module dly_update_ctrl
  import dlyu_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int OFF_W     = 6,
  parameter int PERIOD    = 8,
  parameter int INTRINSIC = 20,
  parameter int STEP      = 5,
  localparam int DLY_W    = $clog2(4 * (INTRINSIC + ((1 << CODE_W) - 1) * STEP) + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSel,
  input  logic              refTick,
  input  logic              userTick,
  input  logic              srcSel,
  input  logic [CODE_W-1:0] dllCode,
  input  logic [CODE_W-1:0] coreCode,
  input  logic              narrowMode,
  input  logic [1:0]        elemSel,
  input  logic [OFF_W-1:0]  phaseIn,
  input  logic              bypassIn,
  output logic              updEn,
  output logic [CODE_W-1:0] codeOut,
  output logic [CODE_W-1:0] stepsOut,
  output logic [2:0]        elemCount,
  output logic [OFF_W-1:0]  phaseOut,
  output logic              bypassOut,
  output logic [DLY_W-1:0]  delayOut,
  output logic              codeErr
);
  dlyuStrobe_t stb;

  dlyu_ctrl #(.PERIOD(PERIOD)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickSel(tickSel), .refTick(refTick),
    .userTick(userTick), .updEn(updEn), .stb(stb)
  );

  dlyu_datapath #(
    .CODE_W(CODE_W), .OFF_W(OFF_W), .INTRINSIC(INTRINSIC),
    .STEP(STEP), .DLY_W(DLY_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .srcSel(srcSel),
    .dllCode(dllCode), .coreCode(coreCode), .narrowMode(narrowMode),
    .elemSel(elemSel), .phaseIn(phaseIn), .bypassIn(bypassIn),
    .codeOut(codeOut), .stepsOut(stepsOut), .elemCount(elemCount),
    .phaseOut(phaseOut), .bypassOut(bypassOut), .delayOut(delayOut),
    .codeErr(codeErr)
  );

endmodule

// File: rtl/dlyu_chk.sv
module dlyu_chk #(
  parameter int CODE_W = 6,
  parameter int OFF_W  = 6,
  parameter int DLY_W  = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              narrowMode,
  input logic              updEn,
  input logic [CODE_W-1:0] codeOut,
  input logic [2:0]        elemCount,
  input logic [OFF_W-1:0]  phaseOut,
  input logic              bypassOut,
  input logic [DLY_W-1:0]  delayOut,
  input logic              codeErr
);
  // R2
  upd_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    updEn |=> !updEn);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updEn |=> ($stable(codeOut) && $stable(elemCount) && $stable(phaseOut)
                && $stable(bypassOut) && $stable(codeErr)));

  // R7
  one_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    updEn |=> ($countones(codeOut ^ $past(codeOut)) <= 1));

  // R7
  err_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    updEn |=> (!codeErr || $stable(codeOut)));

  // R8
  narrow_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && narrowMode) |=> (codeErr || !codeOut[CODE_W-1]));

  // R9
  elem_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (elemCount >= 3'd1) && (elemCount <= 3'd4));

  // R11
  bypass_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    bypassOut |-> (delayOut == '0));
endmodule

bind dly_update_ctrl dlyu_chk #(.CODE_W(CODE_W), .OFF_W(OFF_W), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rstN(rstN), .narrowMode(narrowMode), .updEn(updEn),
  .codeOut(codeOut), .elemCount(elemCount), .phaseOut(phaseOut),
  .bypassOut(bypassOut), .delayOut(delayOut), .codeErr(codeErr)
);

// File: tb/tb_dly_update_ctrl.sv
module tb_dly_update_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickSel = 1'b0, refTick = 1'b1, userTick = 1'b1, srcSel = 1'b0;
  logic [5:0]  dllCode = '0, coreCode = '0, phaseIn = '0;
  logic        narrowMode = 1'b0, bypassIn = 1'b0;
  logic [1:0]  elemSel = '0;
  logic        updEn, bypassOut, codeErr;
  logic [5:0]  codeOut, stepsOut, phaseOut;
  logic [2:0]  elemCount;
  logic [10:0] delayOut;

  int errs = 0, checks = 0;
  bit done = 0;

  dly_update_ctrl dut (
    .clk(clk), .rstN(rstN), .tickSel(tickSel), .refTick(refTick),
    .userTick(userTick), .srcSel(srcSel), .dllCode(dllCode),
    .coreCode(coreCode), .narrowMode(narrowMode), .elemSel(elemSel),
    .phaseIn(phaseIn), .bypassIn(bypassIn), .updEn(updEn),
    .codeOut(codeOut), .stepsOut(stepsOut), .elemCount(elemCount),
    .phaseOut(phaseOut), .bypassOut(bypassOut), .delayOut(delayOut),
    .codeErr(codeErr)
  );

  always #5 clk = ~clk;

  // model state
  logic [5:0] mCode = '0, mPhase = '0;
  logic [2:0] mElem = 3'd1;
  logic       mByp = 1'b0, mErr = 1'b0, mUpd = 1'b0;
  int         tcnt = 0;

  function automatic logic [5:0] g2b(logic [5:0] g);
    logic [5:0] b;
    b[5] = g[5];
    for (int i = 4; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [5:0] b2g(logic [5:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic int expDelay(logic [2:0] e, logic [5:0] s, logic byp);
    return byp ? 0 : int'(e) * (20 + int'(s) * 5);
  endfunction

  task automatic chkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    chkEq("R2 R3 updEn cadence", int'(updEn), int'(mUpd));
    chkEq("R4 R5 R7 codeOut", int'(codeOut), int'(mCode));
    chkEq("R6 stepsOut", int'(stepsOut), int'(g2b(mCode)));
    chkEq("R7 codeErr", int'(codeErr), int'(mErr));
    chkEq("R9 elemCount", int'(elemCount), int'(mElem));
    chkEq("R12 phaseOut", int'(phaseOut), int'(mPhase));
    chkEq("R11 bypassOut", int'(bypassOut), int'(mByp));
    chkEq("R10 R11 delayOut", int'(delayOut), expDelay(mElem, g2b(mCode), mByp));
  endtask

  // model of one edge, using the inputs present now
  task automatic advanceModel();
    logic [5:0] cand;
    logic       tk;
    if (mUpd) begin
      cand = srcSel ? coreCode : dllCode;   // R5
      if (narrowMode) cand[5] = 1'b0;       // R8
      if ($countones(cand ^ mCode) > 1) mErr = 1'b1;
      else begin mErr = 1'b0; mCode = cand; end
      mElem  = {1'b0, elemSel} + 3'd1;
      mPhase = phaseIn;
      mByp   = bypassIn;
    end
    tk = tickSel ? userTick : refTick;
    mUpd = 1'b0;
    if (tk) begin
      if (tcnt == 7) begin tcnt = 0; mUpd = 1'b1; end
      else tcnt++;
    end
  endtask

  task automatic randomInputs(int i);
    logic [5:0] base, nb, junk;
    int r;
    junk = 6'($urandom);
    base = narrowMode ? g2b({1'b0, mCode[4:0]}) : g2b(mCode);
    r = $urandom_range(0, 2);
    nb = (r == 0) ? base : (r == 1) ? base + 6'd1 : base - 6'd1;
    if (i >= 1800 && i < 2400) nb[5] = 1'b0;
    nb = b2g(nb);
    if (i >= 1800 && i < 2400) nb[5] = 1'($urandom);  // R8 garbage in bit 5
    if ((i >= 2400 && i < 3000 && $urandom_range(0, 9) < 3) ||
        (i >= 3000 && $urandom_range(0, 9) < 2))
      nb = 6'($urandom);                                // R7 jumps
    srcSel = 1'($urandom);
    if (srcSel) begin coreCode = nb; dllCode = junk; end
    else begin dllCode = nb; coreCode = junk; end
    elemSel  = 2'($urandom);
    phaseIn  = 6'($urandom);
    bypassIn = ($urandom_range(0, 3) == 0);
    narrowMode = (i >= 1800 && i < 2400) ? 1'b1 :
                 (i >= 3000) ? 1'($urandom) : 1'b0;
    if (i < 600) begin
      tickSel = 1'b0; refTick = 1'b1; userTick = 1'($urandom);
    end else if (i < 1200) begin
      tickSel = 1'b0; refTick = 1'($urandom); userTick = 1'b1;  // R3
    end else if (i < 1800) begin
      tickSel = 1'b1; userTick = 1'($urandom); refTick = 1'b1;  // R3
    end else begin
      tickSel = 1'($urandom); refTick = 1'($urandom); userTick = 1'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state while reset is held
    repeat (3) @(negedge clk);
    checkAll();
    chkEq("R1 reset codeOut", int'(codeOut), 0);
    chkEq("R1 reset elemCount", int'(elemCount), 1);
    rstN = 1'b1;
    // R2: with continuous ticks the first pulse follows the 8th edge
    for (int k = 0; k < 8; k++) begin
      advanceModel();
      @(negedge clk);
      chkEq("R1 R2 no early updEn", int'(updEn), (k == 7) ? 1 : 0);
      checkAll();
    end
    for (int i = 0; i < 4000; i++) begin
      advanceModel();
      @(negedge clk);
      checkAll();
      randomInputs(i);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule